// File: doc/BRIEF.md
# Dual-Width Register Rename Unit

This block renames up to two decoded instructions per cycle on their way into the reorder buffer. It keeps one entry for each architectural register, integer and floating point in one index space. Each entry holds a pending flag and the tag of the youngest in-flight instruction that writes that register. Every instruction that writes a register receives a fresh tag from a counter that only moves forward. Each source operand leaves the block in one of three forms: a producer tag to wait on, a marker that the architectural register already holds the value, or a constant (immediate) marker that needed no lookup.

The two slots of a pair are handled in program order. Slot 1 sees slot 0's new tag when it reads slot 0's destination. When both slots write the same register, slot 1's tag is the one kept in the map. A two-lane commit port reports retired tags in order. A retiring tag clears its register's entry only if the entry still holds that tag. The block stops accepting work before the tag counter could reach a tag that is still in flight.

Top module: `dual_rename`

## Requirements
- R1: After reset `ren_ready_o` is 1, no register has a pending producer, and the first tag handed out is 1.
- R2: Each accepted slot with `ren_dst_we_i` set gets a new nonzero tag. Slot 0 is served before slot 1, and each new tag is one step past the previous one.
- R3: An accepted slot with `ren_dst_we_i` clear (branch, store) reports destination tag 0, uses no tag and leaves the map unchanged.
- R4: A source register with no pending producer is reported with kind 0 (architectural, ready) and tag 0.
- R5: A source register with a pending producer is reported with kind 1 and the tag of the youngest accepted writer of that register.
- R6: When `ren_src2_imm_i` is set, source 2 is reported with kind 2 (constant) and tag 0, whatever the map holds.
- R7: When slot 1 reads the register that slot 0 of the same pair writes, slot 1 gets slot 0's new tag with kind 1.
- R8: When both slots of a pair write the same register, later readers see slot 1's tag.
- R9: A commit of (register, tag) clears the entry only if the entry is pending and holds that tag. Otherwise the entry is untouched.
- R10: A source whose entry is cleared by a commit in the same cycle reads as kind 0. A rename write and a commit clear that hit the same register in the same cycle leave the new tag in place.
- R11: The tag that follows the all-ones value is 1. Tag 0 is never handed out.
- R12: `ren_ready_o` is 1 exactly when the number of allocated, uncommitted tags is at most 2^TAG_W-3. It depends only on state.
- R13: `out_valid_o[k]` equals `ren_valid_i[k]` AND `ren_ready_o`. Nothing is renamed or allocated while ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 2 | Slot holds an instruction (bit 0 is older) |
| ren_dst_we_i | input | 2 | Slot writes a destination register |
| ren_dst_i | input | 2x$clog2(NUM_REGS) | Destination register per slot |
| ren_src1_i | input | 2x$clog2(NUM_REGS) | Source 1 register per slot |
| ren_src2_i | input | 2x$clog2(NUM_REGS) | Source 2 register per slot |
| ren_src2_imm_i | input | 2 | Source 2 is a constant |
| ren_ready_o | output | 1 | Block accepts instructions this cycle |
| out_valid_o | output | 2 | Renamed slot is valid |
| out_dst_tag_o | output | 2xTAG_W | New destination tag, 0 if none |
| out_src1_kind_o | output | 2x2 | Source 1 kind: 0 ready, 1 tag, 2 constant |
| out_src1_tag_o | output | 2xTAG_W | Source 1 producer tag |
| out_src2_kind_o | output | 2x2 | Source 2 kind |
| out_src2_tag_o | output | 2xTAG_W | Source 2 producer tag |
| cmt_valid_i | input | 2 | Commit lane active (bit 0 is older) |
| cmt_reg_i | input | 2x$clog2(NUM_REGS) | Register of the retiring instruction |
| cmt_tag_i | input | 2xTAG_W | Tag of the retiring instruction |

## Verification
Renaming and retirement can act on the same map entry in the same cycle. The bench provokes this with a commit of a register's live tag while a slot reads that register, and again while a slot writes it. A reader must then see kind 0, and a writer's tag must survive the clear. The bench also retires a stale tag of a register that has since been rewritten. A behavioural reference model (queues and integer arrays) predicts every output on every clock, including the wrap of a narrow tag counter and the stall when the live window fills.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int SLOTS = 2;

  typedef enum logic [1:0] {
    SRC_ARCH = 2'd0,
    SRC_TAG  = 2'd1,
    SRC_IMM  = 2'd2
  } src_kind_e;
endpackage

// File: rtl/rn_tag_alloc.sv
module rn_tag_alloc #(
  parameter int TAG_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     alloc_i,
  input  logic [1:0]                     retire_i,
  output logic [1:0][TAG_W-1:0]          tag_o,
  output logic                           ready_o
);
  localparam int unsigned LIVE_MAX = (1 << TAG_W) - 3;

  logic [TAG_W-1:0] next_q, next_d;
  logic [TAG_W:0]   live_q, live_d;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] t);
    return (t == '1) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  always_comb begin
    next_d = next_q;
    for (int k = 0; k < 2; k++) begin
      tag_o[k] = next_d;
      if (alloc_i[k]) next_d = bump(next_d);
    end
  end

  assign live_d = live_q
                + (TAG_W+1)'(alloc_i[0]) + (TAG_W+1)'(alloc_i[1])
                - (TAG_W+1)'(retire_i[0]) - (TAG_W+1)'(retire_i[1]);

  // stall depends on state only; two free tags are always kept in reserve
  assign ready_o = (live_q <= (TAG_W+1)'(LIVE_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= TAG_W'(1);
      live_q <= '0;
    end else begin
      next_q <= next_d;
      live_q <= live_d;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_REGS = 64,
  parameter int TAG_W    = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [3:0][REG_W-1:0]     rd_reg_i,
  output logic [3:0]                rd_pend_o,
  output logic [3:0][TAG_W-1:0]     rd_tag_o,
  input  logic [1:0]                wr_en_i,
  input  logic [1:0][REG_W-1:0]     wr_reg_i,
  input  logic [1:0][TAG_W-1:0]     wr_tag_i,
  input  logic [1:0]                clr_en_i,
  input  logic [1:0][REG_W-1:0]     clr_reg_i,
  input  logic [1:0][TAG_W-1:0]     clr_tag_i
);
  logic             pend_q [NUM_REGS];
  logic [TAG_W-1:0] tag_q  [NUM_REGS];
  logic [NUM_REGS-1:0] clr_hit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < 2; k++)
        if (clr_en_i[k] && clr_reg_i[k] == REG_W'(r) && pend_q[r] && tag_q[r] == clr_tag_i[k])
          hit = 1'b1;
    end
    assign clr_hit[r] = hit;

    // younger slot wins, any rename wins over a retirement clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end else if (wr_en_i[1] && wr_reg_i[1] == REG_W'(r)) begin
        pend_q[r] <= 1'b1;
        tag_q[r]  <= wr_tag_i[1];
      end else if (wr_en_i[0] && wr_reg_i[0] == REG_W'(r)) begin
        pend_q[r] <= 1'b1;
        tag_q[r]  <= wr_tag_i[0];
      end else if (hit) begin
        pend_q[r] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_rd
    assign rd_pend_o[i] = pend_q[rd_reg_i[i]] & ~clr_hit[rd_reg_i[i]];
    assign rd_tag_o[i]  = tag_q[rd_reg_i[i]];
  end
endmodule

// File: rtl/rn_src_resolve.sv
module rn_src_resolve
  import rn_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             en_i,
  input  logic             imm_i,
  input  logic             byp_i,
  input  logic [TAG_W-1:0] byp_tag_i,
  input  logic             map_pend_i,
  input  logic [TAG_W-1:0] map_tag_i,
  output logic [1:0]       kind_o,
  output logic [TAG_W-1:0] tag_o
);
  src_kind_e kind;

  always_comb begin
    kind  = SRC_ARCH;
    tag_o = '0;
    if (en_i) begin
      if (imm_i) begin
        kind = SRC_IMM;
      end else if (byp_i) begin
        kind  = SRC_TAG;
        tag_o = byp_tag_i;
      end else if (map_pend_i) begin
        kind  = SRC_TAG;
        tag_o = map_tag_i;
      end
    end
  end

  assign kind_o = kind;
endmodule

// File: rtl/dual_rename.sv
module dual_rename
  import rn_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int TAG_W    = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [SLOTS-1:0]             ren_valid_i,
  input  logic [SLOTS-1:0]             ren_dst_we_i,
  input  logic [SLOTS-1:0][REG_W-1:0]  ren_dst_i,
  input  logic [SLOTS-1:0][REG_W-1:0]  ren_src1_i,
  input  logic [SLOTS-1:0][REG_W-1:0]  ren_src2_i,
  input  logic [SLOTS-1:0]             ren_src2_imm_i,
  output logic                         ren_ready_o,
  output logic [SLOTS-1:0]             out_valid_o,
  output logic [SLOTS-1:0][TAG_W-1:0]  out_dst_tag_o,
  output logic [SLOTS-1:0][1:0]        out_src1_kind_o,
  output logic [SLOTS-1:0][TAG_W-1:0]  out_src1_tag_o,
  output logic [SLOTS-1:0][1:0]        out_src2_kind_o,
  output logic [SLOTS-1:0][TAG_W-1:0]  out_src2_tag_o,
  input  logic [SLOTS-1:0]             cmt_valid_i,
  input  logic [SLOTS-1:0][REG_W-1:0]  cmt_reg_i,
  input  logic [SLOTS-1:0][TAG_W-1:0]  cmt_tag_i
);
  logic [SLOTS-1:0]            fire, alloc;
  logic [SLOTS-1:0][TAG_W-1:0] new_tag;
  logic [3:0][REG_W-1:0]       rd_reg;
  logic [3:0]                  rd_pend;
  logic [3:0][TAG_W-1:0]       rd_tag;

  assign fire  = ren_valid_i & {SLOTS{ren_ready_o}};
  assign alloc = fire & ren_dst_we_i;

  rn_tag_alloc #(.TAG_W(TAG_W)) u_alloc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (alloc),
    .retire_i (cmt_valid_i),
    .tag_o    (new_tag),
    .ready_o  (ren_ready_o)
  );

  assign rd_reg = {ren_src2_i[1], ren_src1_i[1], ren_src2_i[0], ren_src1_i[0]};

  rn_map_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_reg_i  (rd_reg),
    .rd_pend_o (rd_pend),
    .rd_tag_o  (rd_tag),
    .wr_en_i   (alloc),
    .wr_reg_i  (ren_dst_i),
    .wr_tag_i  (new_tag),
    .clr_en_i  (cmt_valid_i),
    .clr_reg_i (cmt_reg_i),
    .clr_tag_i (cmt_tag_i)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic byp1, byp2;
    // only the younger slot can depend on its partner
    if (k == 0) begin : g_old
      assign byp1 = 1'b0;
      assign byp2 = 1'b0;
    end else begin : g_young
      assign byp1 = alloc[0] && ren_dst_i[0] == ren_src1_i[k];
      assign byp2 = alloc[0] && ren_dst_i[0] == ren_src2_i[k];
    end

    assign out_valid_o[k]   = fire[k];
    assign out_dst_tag_o[k] = alloc[k] ? new_tag[k] : '0;

    rn_src_resolve #(.TAG_W(TAG_W)) u_src1 (
      .en_i       (fire[k]),
      .imm_i      (1'b0),
      .byp_i      (byp1),
      .byp_tag_i  (new_tag[0]),
      .map_pend_i (rd_pend[2*k]),
      .map_tag_i  (rd_tag[2*k]),
      .kind_o     (out_src1_kind_o[k]),
      .tag_o      (out_src1_tag_o[k])
    );

    rn_src_resolve #(.TAG_W(TAG_W)) u_src2 (
      .en_i       (fire[k]),
      .imm_i      (ren_src2_imm_i[k]),
      .byp_i      (byp2),
      .byp_tag_i  (new_tag[0]),
      .map_pend_i (rd_pend[2*k+1]),
      .map_tag_i  (rd_tag[2*k+1]),
      .kind_o     (out_src2_kind_o[k]),
      .tag_o      (out_src2_tag_o[k])
    );
  end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int NUM_REGS = 64,
  parameter int TAG_W    = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ren_ready_o,
  input logic [1:0]            ren_valid_i,
  input logic [1:0]            out_valid_o,
  input logic [1:0]            ren_dst_we_i,
  input logic [1:0][REG_W-1:0] ren_dst_i,
  input logic [1:0][REG_W-1:0] ren_src1_i,
  input logic [1:0]            ren_src2_imm_i,
  input logic [1:0][TAG_W-1:0] out_dst_tag_o,
  input logic [1:0][1:0]       out_src1_kind_o,
  input logic [1:0][TAG_W-1:0] out_src1_tag_o,
  input logic [1:0][1:0]       out_src2_kind_o,
  input logic [1:0][TAG_W-1:0] out_src2_tag_o,
  input logic [1:0]            cmt_valid_i
);
  function automatic logic [TAG_W-1:0] step_tag(input logic [TAG_W-1:0] t);
    return (t == '1) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  p_gate_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ready_o |-> out_valid_o == 2'b00);

  p_accept_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ready_o |-> out_valid_o == ren_valid_i);

  p_no_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o[0] && !ren_dst_we_i[0]) || (out_valid_o[1] && !ren_dst_we_i[1])
    |-> (out_valid_o[0] && !ren_dst_we_i[0] ? out_dst_tag_o[0] == '0 : 1'b1) &&
        (out_valid_o[1] && !ren_dst_we_i[1] ? out_dst_tag_o[1] == '0 : 1'b1));

  p_tag_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[0] && ren_dst_we_i[0] |-> out_dst_tag_o[0] != '0);

  p_pair_seq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == 2'b11 && ren_dst_we_i == 2'b11 |-> out_dst_tag_o[1] == step_tag(out_dst_tag_o[0]));

  p_imm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[1] && ren_src2_imm_i[1] |-> out_src2_kind_o[1] == 2'd2 && out_src2_tag_o[1] == '0);

  p_pair_raw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == 2'b11 && ren_dst_we_i[0] && ren_src1_i[1] == ren_dst_i[0]
    |-> out_src1_kind_o[1] == 2'd1 && out_src1_tag_o[1] == out_dst_tag_o[0]);

  p_wake_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ren_ready_o) |-> $past(|cmt_valid_i));
endmodule

bind dual_rename rn_rename_chk #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_dual_rename.sv
`timescale 1ns/1ps
module sim_dual_rename;
  localparam int NREG = 64;
  localparam int RW   = 6;
  localparam int TW   = 4;
  localparam int MAXT = (1 << TW) - 1;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [1:0] valid, we, imm, cv;
  logic [1:0][RW-1:0] dst, s1, s2, creg;
  logic [1:0][TW-1:0] ctag;
  logic ready;
  logic [1:0] ovalid;
  logic [1:0][TW-1:0] odst, os1t, os2t;
  logic [1:0][1:0] os1k, os2k;

  dual_rename #(.NUM_REGS(NREG), .TAG_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(valid), .ren_dst_we_i(we), .ren_dst_i(dst),
    .ren_src1_i(s1), .ren_src2_i(s2), .ren_src2_imm_i(imm),
    .ren_ready_o(ready), .out_valid_o(ovalid), .out_dst_tag_o(odst),
    .out_src1_kind_o(os1k), .out_src1_tag_o(os1t),
    .out_src2_kind_o(os2k), .out_src2_tag_o(os2t),
    .cmt_valid_i(cv), .cmt_reg_i(creg), .cmt_tag_i(ctag));

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  int m_pend[NREG], m_tag[NREG];
  int m_next = 1, m_live = 0;
  int q_reg[$], q_tag[$];

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  task automatic set_slot(int k, bit v, bit w, int d, int a, int b, bit im);
    valid[k] = v; we[k] = w; dst[k] = RW'(d); s1[k] = RW'(a); s2[k] = RW'(b); imm[k] = im;
  endtask

  task automatic idle();
    set_slot(0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic step(int ncom);
    int nc, t, er, ek, et;
    int etag[2];
    bit ev;
    bit clr[NREG];
    nc = (ncom < q_reg.size()) ? ncom : q_reg.size();
    cv = '0;
    for (int i = 0; i < 2; i++) begin
      cv[i] = (i < nc);
      creg[i] = (i < nc) ? RW'(q_reg[i]) : '0;
      ctag[i] = (i < nc) ? TW'(q_tag[i]) : '0;
    end
    for (int r = 0; r < NREG; r++) begin
      clr[r] = 0;
      for (int i = 0; i < nc; i++)
        if (q_reg[i] == r && m_pend[r] != 0 && m_tag[r] == q_tag[i]) clr[r] = 1;
    end
    #1;
    er = (m_live <= MAXT - 2);
    chk("R12 ready", 32'(ready), 32'(er));
    t = m_next;
    for (int k = 0; k < 2; k++) begin
      ev = valid[k] && er != 0;
      chk($sformatf("R13 valid%0d", k), 32'(ovalid[k]), 32'(ev));
      etag[k] = 0;
      if (ev && we[k]) begin
        etag[k] = t;
        t = (t == MAXT) ? 1 : t + 1;
      end
      if (ev) begin
        chk($sformatf("R2 dst%0d", k), 32'(odst[k]), 32'(etag[k]));
        for (int s = 0; s < 2; s++) begin
          int r;
          r = (s == 0) ? int'(s1[k]) : int'(s2[k]);
          if (s == 1 && imm[k]) begin ek = 2; et = 0; end
          else if (k == 1 && etag[0] != 0 && int'(dst[0]) == r) begin ek = 1; et = etag[0]; end
          else if (m_pend[r] != 0 && !clr[r]) begin ek = 1; et = m_tag[r]; end
          else begin ek = 0; et = 0; end
          chk($sformatf("R5 slot%0d src%0d kind", k, s + 1), 32'((s == 0) ? os1k[k] : os2k[k]), 32'(ek));
          chk($sformatf("R5 slot%0d src%0d tag", k, s + 1), 32'((s == 0) ? os1t[k] : os2t[k]), 32'(et));
        end
      end
    end
    for (int r = 0; r < NREG; r++) if (clr[r]) m_pend[r] = 0;
    for (int i = 0; i < nc; i++) begin void'(q_reg.pop_front()); void'(q_tag.pop_front()); end
    m_live -= nc;
    for (int k = 0; k < 2; k++)
      if (etag[k] != 0) begin
        m_pend[int'(dst[k])] = 1; m_tag[int'(dst[k])] = etag[k];
        q_reg.push_back(int'(dst[k])); q_tag.push_back(etag[k]);
        m_live++;
      end
    m_next = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    idle();
    while (q_reg.size() > 0) step(2);
  endtask

  function automatic int rreg();
    int v = $urandom_range(0, 7);
    return ($urandom_range(0, 1) != 0) ? v + 32 : v;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin m_pend[r] = 0; m_tag[r] = 0; end
    idle(); cv = '0; creg = '0; ctag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, first tag is 1; R4: unwritten sources are ready
    phase = "R1 reset";
    chk("R1 ready after reset", 32'(ready), 32'd1);
    set_slot(0, 1, 1, 2, 5, 40, 0);
    step(0);
    phase = "R4 arch source";
    idle(); set_slot(0, 1, 1, 3, 6, 41, 0); set_slot(1, 1, 1, 4, 7, 33, 0);
    step(0);

    // R5: sources that hit pending writers
    phase = "R5 pending source";
    idle(); set_slot(0, 1, 1, 9, 2, 3, 0); set_slot(1, 1, 0, 0, 4, 2, 0);
    step(0);

    // R3: store/branch slots take no tag
    phase = "R3 no dest";
    idle(); set_slot(0, 1, 0, 9, 2, 3, 0); set_slot(1, 1, 1, 10, 9, 9, 0);
    step(1);

    // R6: immediate ignores a pending map entry
    phase = "R6 immediate";
    idle(); set_slot(0, 1, 1, 11, 3, 9, 1); set_slot(1, 1, 1, 12, 9, 10, 1);
    step(0);

    // R7: slot 1 reads slot 0's destination
    phase = "R7 pair RAW";
    idle(); set_slot(0, 1, 1, 34, 34, 35, 0); set_slot(1, 1, 1, 36, 34, 34, 0);
    step(2);

    // R8: both slots write the same register, then read it
    phase = "R8 pair WAW";
    idle(); set_slot(0, 1, 1, 37, 1, 1, 0); set_slot(1, 1, 1, 37, 37, 2, 0);
    step(0);
    idle(); set_slot(0, 1, 0, 0, 37, 37, 0);
    step(0);
    drain();

    // R9: stale retirement leaves a newer mapping alone
    phase = "R9 stale commit";
    idle(); set_slot(0, 1, 1, 3, 0, 0, 0); step(0);
    idle(); set_slot(0, 1, 1, 3, 0, 0, 0); step(0);
    idle(); set_slot(0, 1, 0, 0, 3, 3, 0); step(1);
    idle(); set_slot(0, 1, 0, 0, 3, 3, 0); step(0);

    // R10: retirement and rename meet on one register
    phase = "R10 same-cycle clear";
    idle(); set_slot(0, 1, 0, 0, 3, 3, 0); step(1);
    idle(); set_slot(0, 1, 0, 0, 3, 3, 0); step(0);
    idle(); set_slot(0, 1, 1, 3, 1, 1, 0); step(0);
    phase = "R10 write beats clear";
    idle(); set_slot(0, 1, 1, 3, 1, 1, 0); set_slot(1, 1, 0, 0, 3, 3, 0); step(1);
    idle(); set_slot(0, 1, 0, 0, 3, 3, 0); step(1);
    drain();

    // R12: fill the live window without commits, then release
    phase = "R12 stall";
    for (int i = 0; i < 9; i++) begin
      idle(); set_slot(0, 1, 1, i, 0, 0, 0); set_slot(1, 1, 1, i + 32, i, 0, 0);
      step(0);
    end
    chk("R12 ready low when window full", 32'(ready), 32'd0);
    idle(); set_slot(0, 1, 1, 5, 5, 5, 0); step(2);
    drain();

    // R11: run the narrow counter through several wraps
    phase = "R11 wrap";
    for (int i = 0; i < 40; i++) begin
      idle(); set_slot(0, 1, 1, i % 8, (i + 1) % 8, 33, 0); set_slot(1, 1, 1, 40, i % 8, 40, 0);
      step(2);
    end

    // mixed traffic against the model
    phase = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < 2; k++)
        set_slot(k, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                 rreg(), rreg(), rreg(), $urandom_range(0, 3) == 0);
      step($urandom_range(0, 2));
    end
    drain();
    finish_run();
  end
endmodule